// File: doc/BRIEF.md
# Interleaved Private Scratch Address Generator

This block turns a lane's private byte offset into the physical byte address it occupies in a scratch area shared by all lanes of a wavefront. The scratch area is not laid out as one contiguous slice per lane. Instead, lane memory is interleaved at a selectable element granularity of 2, 4, 8 or 16 bytes, with an index stride equal to the lane count. Element number n of every lane therefore sits in one contiguous run of stride × E bytes, and inside that run each lane has its own E-byte slot. The lane index is always folded into the address.

Each request carries these inputs:
- the dispatch scratch base
- a per-wave byte offset
- the lane's private offset
- an element-size code
- an access-size code
- the lane index

The block first adds the base and the wave offset, then places the interleaved offset on top of that sum. It also raises an error flag when the access would not fit inside one element. Such an access would spill into the neighbouring lane's slot, so a wide access has to be split into element-sized pieces upstream.

The result goes through a single valid/ready register stage, so an accepted request appears on the output one clock later.

Top module: `sxa_scratch_agen`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: The element-size code picks E: code 0 gives 2 bytes, 1 gives 4, 2 gives 8 and 3 gives 16. The address is base + wave_off + floor(priv_off/E)·E·64 + lane·E + (priv_off mod E), computed modulo 2^64.
- R3: For the same private offset, consecutive lane indices give addresses exactly E apart. Adding E to the private offset moves the address by E·64.
- R4: The low log2(E) bits of (address − base − wave_off) equal priv_off mod E.
- R5: The base and the zero-extended 32-bit wave offset are summed before the interleave term is added, and the whole sum wraps modulo 2^64.
- R6: The access size in bytes is 2^acc_code, where acc_code is 3 bits. `out_err` is 1 whenever that size exceeds E.
- R7: `out_err` is 1 when (priv_off mod E) + access size exceeds E, and 0 when the access fits inside one element.
- R8: A request accepted on a clock edge (in_valid and in_ready both high) is presented with `out_valid` high right after that edge.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_addr` and `out_err` hold, `out_valid` stays 1, and `in_ready` is 0.
- R10: `in_ready` is 1 whenever the output register is empty or is being drained in the same cycle. A drained register with no new request goes empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted this cycle when in_valid is high |
| scr_base | input | 64 | Dispatch scratch base byte address |
| wave_off | input | 32 | Per-wave byte offset from the base |
| priv_off | input | 32 | Lane-private byte offset |
| elem_code | input | 2 | Element size code (2/4/8/16 bytes) |
| acc_code | input | 3 | Access size, log2 of bytes |
| lane_id | input | 6 | Lane index within the wavefront |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_addr | output | 64 | Physical byte address for the lane |
| out_err | output | 1 | Access crosses an element boundary |

## Verification
All four element codes are tried with one fixed lane and offset. This separates the shift amount used for the chunk term from the one used for the lane term.

Lane sweeps (0, 1, 63) and private offsets that straddle element boundaries test the stride and the in-element remainder. A base near 2^64 tests the wrap of the base sum.

Access sizes are placed just inside and just outside an element, at zero and non-zero remainders. This separates the two causes of the error flag.

Stalls with a held consumer, back-to-back streaming, and a long pseudo-random mix of all fields with random backpressure test the register stage against the cycle model.

// File: rtl/sxa_pkg.sv
package sxa_pkg;

   typedef enum logic [1:0] {
      ELEM_2B  = 2'd0,
      ELEM_4B  = 2'd1,
      ELEM_8B  = 2'd2,
      ELEM_16B = 2'd3
   } elem_code_e;

   // log2 of element bytes for a given element code
   function automatic int unsigned elem_log2(input logic [1:0] code);
      return int'(code) + 1;
   endfunction

   // in-element byte mask for a given code, 64-bit wide
   function automatic logic [63:0] elem_mask64(input logic [1:0] code);
      return (64'd2 << code) - 64'd1;
   endfunction

endpackage

// File: rtl/sxa_wave_base.sv
module sxa_wave_base #(
   parameter int ADDR_W = 64,
   parameter int WOFF_W = 32
) (
   input  logic [ADDR_W-1:0] base_i,
   input  logic [WOFF_W-1:0] woff_i,
   output logic [ADDR_W-1:0] sum_o
);
   generate
      if (WOFF_W > ADDR_W) begin : g_bad_w
         $error("sxa_wave_base: WOFF_W must not exceed ADDR_W");
      end
   endgenerate

   localparam int PAD_W = ADDR_W - WOFF_W;

   logic [ADDR_W-1:0] woff_ext;

   generate
      if (PAD_W > 0) begin : g_pad
         assign woff_ext = {{PAD_W{1'b0}}, woff_i};
      end else begin : g_nopad
         assign woff_ext = woff_i;
      end
   endgenerate

   assign sum_o = base_i + woff_ext;
endmodule

// File: rtl/sxa_swizzle.sv
module sxa_swizzle #(
   parameter int ADDR_W = 64,
   parameter int OFF_W  = 32,
   parameter int LANE_W = 6,
   parameter int ESZ_W  = 2
) (
   input  logic [OFF_W-1:0]  priv_i,
   input  logic [LANE_W-1:0] lane_i,
   input  logic [ESZ_W-1:0]  code_i,
   output logic [ADDR_W-1:0] swz_o
);
   localparam int NUM_ESZ = 1 << ESZ_W;
   localparam int MAX_SH  = NUM_ESZ;

   generate
      if (ADDR_W < OFF_W + LANE_W + 1) begin : g_bad_w
         $error("sxa_swizzle: ADDR_W too narrow for offset and lane stride");
      end
      if (LANE_W < 1) begin : g_bad_lane
         $error("sxa_swizzle: LANE_W must be at least 1");
      end
      if (MAX_SH >= OFF_W) begin : g_bad_esz
         $error("sxa_swizzle: element size too large for OFF_W");
      end
   endgenerate

   logic [ADDR_W-1:0] priv_ext;
   logic [ADDR_W-1:0] lane_ext;
   logic [ADDR_W-1:0] cand [NUM_ESZ];

   assign priv_ext = ADDR_W'(priv_i);
   assign lane_ext = ADDR_W'(lane_i);

   // one candidate per element size; the code picks one
   generate
      for (genvar g = 0; g < NUM_ESZ; g++) begin : g_esz
         localparam int SH = g + 1;
         localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << SH) - 1);
         logic [ADDR_W-1:0] chunk_term;
         logic [ADDR_W-1:0] lane_term;
         logic [ADDR_W-1:0] rem_term;
         assign chunk_term = (priv_ext >> SH) << (SH + LANE_W);
         assign lane_term  = lane_ext << SH;
         assign rem_term   = priv_ext & LOW_MASK;
         assign cand[g]    = chunk_term + lane_term + rem_term;
      end
   endgenerate

   always_comb begin
      swz_o = cand[code_i];
   end
endmodule

// File: rtl/sxa_bound_check.sv
module sxa_bound_check #(
   parameter int OFF_W = 32,
   parameter int ESZ_W = 2,
   parameter int ASZ_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chk_en_i,
   input  logic [OFF_W-1:0] priv_i,
   input  logic [ESZ_W-1:0] code_i,
   input  logic [ASZ_W-1:0] asz_i,
   output logic             err_o
);
   localparam int NUM_ESZ = 1 << ESZ_W;
   localparam int SZ_W    = (1 << ASZ_W) + 1;

   generate
      if (SZ_W <= NUM_ESZ + 1) begin : g_bad_sz
         $error("sxa_bound_check: size arithmetic narrower than element size");
      end
   endgenerate

   logic [SZ_W-1:0] elem_bytes;
   logic [SZ_W-1:0] acc_bytes;
   logic [SZ_W-1:0] rem;
   logic [SZ_W-1:0] reach;
   logic            too_wide;
   logic            crosses;

   assign elem_bytes = SZ_W'(2) << code_i;
   assign acc_bytes  = SZ_W'(1) << asz_i;
   assign rem        = SZ_W'(priv_i) & (elem_bytes - SZ_W'(1));
   assign reach      = rem + acc_bytes;
   assign too_wide   = acc_bytes > elem_bytes;
   assign crosses    = reach > elem_bytes;
   assign err_o      = too_wide | crosses;

   AST_WIDE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_en_i && (asz_i > ASZ_W'(code_i) + ASZ_W'(1))) |-> err_o); // R6

endmodule

// File: rtl/sxa_out_stage.sv
module sxa_out_stage #(
   parameter int W = 65
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] out_data
);
   logic         vld_q;
   logic [W-1:0] data_q;
   logic         take;

   assign in_ready  = !vld_q || out_ready;
   assign take      = in_valid && in_ready;
   assign out_valid = vld_q;
   assign out_data  = data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         data_q <= '0;
      end else begin
         if (in_ready) vld_q <= in_valid;
         if (take)     data_q <= in_data;
      end
   end

   AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid); // R8

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9

   AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && !in_valid) |=> !out_valid); // R10

endmodule

// File: rtl/sxa_scratch_agen.sv
module sxa_scratch_agen #(
   parameter int ADDR_W = 64,
   parameter int WOFF_W = 32,
   parameter int OFF_W  = 32,
   parameter int LANE_W = 6,
   parameter int ESZ_W  = 2,
   parameter int ASZ_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [ADDR_W-1:0] scr_base,
   input  logic [WOFF_W-1:0] wave_off,
   input  logic [OFF_W-1:0]  priv_off,
   input  logic [ESZ_W-1:0]  elem_code,
   input  logic [ASZ_W-1:0]  acc_code,
   input  logic [LANE_W-1:0] lane_id,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [ADDR_W-1:0] out_addr,
   output logic              out_err
);
   import sxa_pkg::*;

   localparam int DATA_W = ADDR_W + 1;

   logic [ADDR_W-1:0] base_sum;
   logic [ADDR_W-1:0] swz_off;
   logic [ADDR_W-1:0] lane_addr;
   logic              lane_err;
   logic [DATA_W-1:0] stage_in;
   logic [DATA_W-1:0] stage_out;

   sxa_wave_base #(
      .ADDR_W (ADDR_W),
      .WOFF_W (WOFF_W)
   ) u_wave_base (
      .base_i (scr_base),
      .woff_i (wave_off),
      .sum_o  (base_sum)
   );

   sxa_swizzle #(
      .ADDR_W (ADDR_W),
      .OFF_W  (OFF_W),
      .LANE_W (LANE_W),
      .ESZ_W  (ESZ_W)
   ) u_swizzle (
      .priv_i (priv_off),
      .lane_i (lane_id),
      .code_i (elem_code),
      .swz_o  (swz_off)
   );

   sxa_bound_check #(
      .OFF_W (OFF_W),
      .ESZ_W (ESZ_W),
      .ASZ_W (ASZ_W)
   ) u_bound_check (
      .clk      (clk),
      .rst_n    (rst_n),
      .chk_en_i (in_valid),
      .priv_i   (priv_off),
      .code_i   (elem_code),
      .asz_i    (acc_code),
      .err_o    (lane_err)
   );

   assign lane_addr = base_sum + swz_off;
   assign stage_in  = {lane_err, lane_addr};

   sxa_out_stage #(
      .W (DATA_W)
   ) u_out_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_data   (stage_in),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_data  (stage_out)
   );

   assign out_addr = stage_out[ADDR_W-1:0];
   assign out_err  = stage_out[ADDR_W];

   generate
      if (ADDR_W == 64 && ESZ_W == 2) begin : g_chk64
         AST_ELEM_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_ready) |=>
            (((out_addr - $past(base_sum)) & elem_mask64($past(elem_code))) ==
             (64'($past(priv_off)) & elem_mask64($past(elem_code))))); // R4
      end
   endgenerate

endmodule

// File: tb/sxa_scratch_agen_bench.sv
`timescale 1ns/100ps
module sxa_scratch_agen_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [63:0] scr_base = '0;
   logic [31:0] wave_off = '0;
   logic [31:0] priv_off = '0;
   logic [1:0]  elem_code = '0;
   logic [2:0]  acc_code = '0;
   logic [5:0]  lane_id = '0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [63:0] out_addr;
   logic        out_err;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   logic [63:0] q_addr[$];
   logic        q_err[$];
   string       q_tag[$];
   bit          prev_stall = 0;
   logic [63:0] prev_addr  = '0;
   logic        prev_err   = 1'b0;

   always #2.5 clk = ~clk;

   sxa_scratch_agen u_sxa_scratch_agen (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .scr_base(scr_base), .wave_off(wave_off), .priv_off(priv_off),
      .elem_code(elem_code), .acc_code(acc_code), .lane_id(lane_id),
      .out_valid(out_valid), .out_ready(out_ready),
      .out_addr(out_addr), .out_err(out_err)
   );

   function automatic logic [63:0] ref_addr(logic [63:0] b, logic [31:0] w,
                                            logic [31:0] p, logic [1:0] ec, logic [5:0] ln);
      logic [63:0] e   = 64'd2 << ec;
      logic [63:0] p64 = {32'd0, p};
      return b + {32'd0, w} + (p64 / e) * e * 64'd64 + {58'd0, ln} * e + (p64 % e);
   endfunction

   function automatic logic ref_err(logic [31:0] p, logic [1:0] ec, logic [2:0] ac);
      int unsigned e   = 2 << ec;
      int unsigned sz  = 1 << ac;
      int unsigned rem = p % e;
      return (sz > e) || (rem + sz > e);
   endfunction

   task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // one cycle: check state, drive, update model, advance to next negedge
   task automatic step(bit v, logic [63:0] b, logic [31:0] w, logic [31:0] p,
                       logic [1:0] ec, logic [2:0] ac, logic [5:0] ln, bit rdy, string tag);
      bit model_rdy;
      check64("R8", {63'd0, out_valid}, {63'd0, q_addr.size() != 0});
      if (q_addr.size() != 0 && out_valid) begin
         check64(q_tag[0], out_addr, q_addr[0]);
         check64({q_tag[0], " R6 R7 err"}, {63'd0, out_err}, {63'd0, q_err[0]});
      end
      if (prev_stall) begin
         check64("R9 addr hold", out_addr, prev_addr);
         check64("R9 err hold", {63'd0, out_err}, {63'd0, prev_err});
      end
      in_valid = v; scr_base = b; wave_off = w; priv_off = p;
      elem_code = ec; acc_code = ac; lane_id = ln; out_ready = rdy;
      #1;
      model_rdy = (q_addr.size() == 0) || rdy;
      check64("R10", {63'd0, in_ready}, {63'd0, model_rdy});
      prev_stall = out_valid && !rdy;
      prev_addr  = out_addr;
      prev_err   = out_err;
      if (rdy && q_addr.size() != 0) begin
         void'(q_addr.pop_front()); void'(q_err.pop_front()); void'(q_tag.pop_front());
      end
      if (v && model_rdy) begin
         q_addr.push_back(ref_addr(b, w, p, ec, ln));
         q_err.push_back(ref_err(p, ec, ac));
         q_tag.push_back(tag);
      end
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check64("R1 valid", {63'd0, out_valid}, 64'd0);
      check64("R1 ready", {63'd0, in_ready}, 64'd1);
      @(negedge clk);

      // R2: every element code, same lane and offset
      for (int c = 0; c < 4; c++)
         step(1, 64'h0000_1000_0000_0000, 32'h200, 32'h35, 2'(c), 3'd0, 6'd5, 1, "R2");
      // R3: lane sweep and chunk step at 4-byte elements
      step(1, 64'h8000, 32'h40, 32'h8, 2'd1, 3'd2, 6'd0,  1, "R3");
      step(1, 64'h8000, 32'h40, 32'h8, 2'd1, 3'd2, 6'd1,  1, "R3");
      step(1, 64'h8000, 32'h40, 32'h8, 2'd1, 3'd2, 6'd63, 1, "R3");
      step(1, 64'h8000, 32'h40, 32'hC, 2'd1, 3'd2, 6'd63, 1, "R3");
      // R4: remainders inside the element
      step(1, 64'h0, 32'h0, 32'h1007, 2'd3, 3'd0, 6'd17, 1, "R4");
      step(1, 64'h0, 32'h0, 32'hFFFF_FFFF, 2'd2, 3'd0, 6'd33, 1, "R4");
      // R5: base plus wave offset wraps
      step(1, 64'hFFFF_FFFF_FFFF_FF00, 32'h0000_0180, 32'h10, 2'd0, 3'd1, 6'd2, 1, "R5");
      // R6: access wider than element, and exactly equal
      step(1, 64'h100, 32'h0, 32'h0, 2'd1, 3'd3, 6'd0, 1, "R6");
      step(1, 64'h100, 32'h0, 32'h0, 2'd3, 3'd4, 6'd0, 1, "R6");
      step(1, 64'h100, 32'h0, 32'h0, 2'd0, 3'd7, 6'd0, 1, "R6");
      // R7: remainder plus size crosses or fits
      step(1, 64'h100, 32'h0, 32'h6, 2'd1, 3'd2, 6'd3, 1, "R7");
      step(1, 64'h100, 32'h0, 32'h6, 2'd1, 3'd1, 6'd3, 1, "R7");
      step(1, 64'h100, 32'h0, 32'hF, 2'd3, 3'd0, 6'd3, 1, "R7");
      step(1, 64'h100, 32'h0, 32'hE, 2'd3, 3'd2, 6'd3, 1, "R7");
      // R9: stall with request pending
      step(1, 64'h2000, 32'h4, 32'h21, 2'd2, 3'd0, 6'd9, 0, "R9");
      step(1, 64'h3000, 32'h8, 32'h22, 2'd1, 3'd0, 6'd8, 0, "R9");
      step(1, 64'h4000, 32'hC, 32'h23, 2'd0, 3'd0, 6'd7, 0, "R9");
      step(1, 64'h4000, 32'hC, 32'h23, 2'd0, 3'd0, 6'd7, 1, "R9");
      // R10: drain with nothing behind, then idle
      step(0, 64'h0, 32'h0, 32'h0, 2'd0, 3'd0, 6'd0, 1, "R10");
      step(0, 64'h0, 32'h0, 32'h0, 2'd0, 3'd0, 6'd0, 1, "R10");
      // mixed traffic with random backpressure
      for (int i = 0; i < 400; i++)
         step(bit'($urandom_range(0, 3) != 0), {$urandom, $urandom}, $urandom, $urandom,
              2'($urandom_range(0, 3)), 3'($urandom_range(0, 5)), 6'($urandom),
              bit'($urandom_range(0, 2) != 0), "R2 R8 mix");
      step(0, 64'h0, 32'h0, 32'h0, 2'd0, 3'd0, 6'd0, 1, "R10");
      step(0, 64'h0, 32'h0, 32'h0, 2'd0, 3'd0, 6'd0, 1, "R10");
      finish_run();
   end
endmodule